// File: doc/BRIEF.md
# Nested Loop Index Controller

This block holds the index counters for five hardware loops that form a strict nest. Loop 4 is the outermost and loop 0 the innermost. Software programs an initial value, a final value and a step for every loop through a small write port. A start pulse then loads every counter with its initial value. From then on, each body-done pulse from the datapath advances the nest by one iteration.

A loop counts as terminating while its index equals its final value. On each body-done pulse the controller finds the run of terminating loops that begins at loop 0. The loop just outside that run adds its step. Every loop inside the run reloads its initial value. When all five loops are terminating, the whole nest reloads and a one-cycle completion pulse follows. The body runs once for every index value, including each final value, so a loop with trip count t is programmed with final = initial + step*(t-1).

The current indices leave the block as one flat bus, with loop k in bits [16k+15:16k]. The datapath uses them directly as its loop variables.

Top module: `loop_nest_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears every index, every programmed bound and `loops_done` to zero.
- R2: When `cfg_we` is high, `cfg_data` is written into the field of loop `cfg_loop` selected by `cfg_field`: 0 = initial value, 1 = final value, 2 = step. A `start` pulse loads every index with its initial value at the next clock edge.
- R3: In a cycle with neither `body_done` nor `start`, no index changes.
- R4: On `body_done` while loop 0 is not at its final value, loop 0 adds its step and every other index holds.
- R5: On `body_done` while loops 0..k (k < 4) are all at their final values and loop k+1 is not, loop k+1 adds its step and loops 0..k reload their initial values in the same edge. Loops above k+1 hold.
- R6: On `body_done` while all five loops are at their final values, every index reloads its initial value and no index steps. `loops_done` is high for exactly the one following cycle.
- R7: Before the first `start` and after completion, `body_done` has no effect on any index until the next `start`.
- R8: Over any programmed bounds, the sequence of index vectors matches a five-deep software nested loop. The number of `body_done` pulses up to completion equals the product of the five trip counts.
- R9: Index arithmetic is modulo 2^16. A step that passes 0xFFFF wraps around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Bound write enable |
| cfg_loop | input | 3 | Loop number for a bound write |
| cfg_field | input | 2 | Field to write: 0 initial, 1 final, 2 step |
| cfg_data | input | 16 | Value to write |
| start | input | 1 | Load initial indices and begin a run |
| body_done | input | 1 | One loop body has finished; advance the nest |
| idx_o | output | 80 | Current indices, loop k in bits [16k+15:16k] |
| loops_done | output | 1 | One-cycle pulse after the whole nest completes |

## Verification
Every index change, whether from `start`, a step or a reload, appears on `idx_o` at the first rising edge after the cycle in which `start` or `body_done` is high. The terminating flags are taken from the registered indices, so there is no further delay. `loops_done` rises at that same edge after the completing pulse and falls one edge later. The bench changes inputs just after a falling edge and reads the outputs at the next falling edge, so each check lands exactly one register stage after its stimulus. Checks for a one-cycle pulse also read the following falling edge.

// File: rtl/nlc_pkg.sv
package nlc_pkg;

    localparam int unsigned DEF_LOOPS = 5;
    localparam int unsigned DEF_IDX_W = 16;

    // bound field selector on the write port
    typedef enum logic [1:0] {
        FLD_INIT  = 2'd0,
        FLD_FINAL = 2'd1,
        FLD_STEP  = 2'd2,
        FLD_NONE  = 2'd3
    } cfg_field_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } run_phase_e;

    // true when v is of the form 0..01..1
    function automatic logic is_thermo(input logic [31:0] v);
        return ((v + 32'd1) & v) == 32'd0;
    endfunction

endpackage

// File: rtl/nlc_bound_regs.sv
module nlc_bound_regs
    import nlc_pkg::*;
#(
    parameter int unsigned N_LOOPS = DEF_LOOPS,
    parameter int unsigned IDX_W   = DEF_IDX_W,
    parameter int unsigned SEL_W   = (N_LOOPS > 1) ? $clog2(N_LOOPS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  cfg_field_e       field,
    input  logic [IDX_W-1:0] data,
    output logic [IDX_W-1:0] init_o [N_LOOPS],
    output logic [IDX_W-1:0] fin_o  [N_LOOPS],
    output logic [IDX_W-1:0] step_o [N_LOOPS]
);

    for (genvar g = 0; g < N_LOOPS; g++) begin : g_bound
        always_ff @(posedge clk) begin
            if (rst) begin
                init_o[g] <= '0;
                fin_o[g]  <= '0;
                step_o[g] <= '0;
            end else if (we && sel == SEL_W'(g)) begin
                case (field)
                    FLD_INIT:  init_o[g] <= data;
                    FLD_FINAL: fin_o[g]  <= data;
                    FLD_STEP:  step_o[g] <= data;
                    default:   ;
                endcase
            end
        end
    end

endmodule

// File: rtl/nlc_term_detect.sv
module nlc_term_detect
    import nlc_pkg::*;
#(
    parameter int unsigned N_LOOPS = DEF_LOOPS,
    parameter int unsigned IDX_W   = DEF_IDX_W
) (
    input  logic [IDX_W-1:0]   idx [N_LOOPS],
    input  logic [IDX_W-1:0]   fin [N_LOOPS],
    output logic [N_LOOPS-1:0] flags
);

    for (genvar g = 0; g < N_LOOPS; g++) begin : g_cmp
        assign flags[g] = (idx[g] == fin[g]);
    end

endmodule

// File: rtl/nlc_nest_decide.sv
module nlc_nest_decide
    import nlc_pkg::*;
#(
    parameter int unsigned N_LOOPS = DEF_LOOPS
) (
    input  logic [N_LOOPS-1:0] flags,
    input  logic               body_done,
    output logic [N_LOOPS-1:0] step_v,
    output logic [N_LOOPS-1:0] reload_v,
    output logic               all_term
);

    // run[i]: loops 0..i are all at their final values
    logic [N_LOOPS-1:0] run;

    always_comb begin
        run[0] = flags[0];
        for (int i = 1; i < N_LOOPS; i++) begin
            run[i] = run[i-1] & flags[i];
        end
    end

    assign reload_v = run;
    assign all_term = run[N_LOOPS-1];

    // innermost loop steps only on a finished body
    assign step_v[0] = ~flags[0] & body_done;

    for (genvar g = 1; g < N_LOOPS; g++) begin : g_step
        assign step_v[g] = run[g-1] & ~flags[g];
    end

endmodule

// File: rtl/nlc_index_bank.sv
module nlc_index_bank
    import nlc_pkg::*;
#(
    parameter int unsigned N_LOOPS = DEF_LOOPS,
    parameter int unsigned IDX_W   = DEF_IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_all,
    input  logic               adv,
    input  logic [N_LOOPS-1:0] step_v,
    input  logic [N_LOOPS-1:0] reload_v,
    input  logic [IDX_W-1:0]   init_i [N_LOOPS],
    input  logic [IDX_W-1:0]   step_i [N_LOOPS],
    output logic [IDX_W-1:0]   idx_o  [N_LOOPS]
);

    for (genvar g = 0; g < N_LOOPS; g++) begin : g_idx
        always_ff @(posedge clk) begin
            if (rst) begin
                idx_o[g] <= '0;
            end else if (load_all) begin
                idx_o[g] <= init_i[g];
            end else if (adv) begin
                if (reload_v[g]) begin
                    idx_o[g] <= init_i[g];
                end else if (step_v[g]) begin
                    idx_o[g] <= idx_o[g] + step_i[g];
                end
            end
        end
    end

endmodule

// File: rtl/loop_nest_ctrl.sv
module loop_nest_ctrl
    import nlc_pkg::*;
#(
    parameter int unsigned N_LOOPS = DEF_LOOPS,
    parameter int unsigned IDX_W   = DEF_IDX_W
) (
    input  logic                                            clk,
    input  logic                                            rst,
    input  logic                                            cfg_we,
    input  logic [((N_LOOPS > 1) ? $clog2(N_LOOPS) : 1)-1:0] cfg_loop,
    input  logic [1:0]                                      cfg_field,
    input  logic [IDX_W-1:0]                                cfg_data,
    input  logic                                            start,
    input  logic                                            body_done,
    output logic [N_LOOPS*IDX_W-1:0]                        idx_o,
    output logic                                            loops_done
);

    localparam int unsigned SEL_W = (N_LOOPS > 1) ? $clog2(N_LOOPS) : 1;

    cfg_field_e         fld;
    logic [IDX_W-1:0]   init_r [N_LOOPS];
    logic [IDX_W-1:0]   fin_r  [N_LOOPS];
    logic [IDX_W-1:0]   step_r [N_LOOPS];
    logic [IDX_W-1:0]   idx_r  [N_LOOPS];
    logic [N_LOOPS-1:0] flags;
    logic [N_LOOPS-1:0] step_v;
    logic [N_LOOPS-1:0] reload_v;
    logic               all_term;
    logic               adv;
    logic               running;
    run_phase_e         phase;

    assign fld     = cfg_field_e'(cfg_field);
    assign running = (phase == PH_RUN);
    assign adv     = running & body_done & ~start;

    nlc_bound_regs #(
        .N_LOOPS(N_LOOPS), .IDX_W(IDX_W), .SEL_W(SEL_W)
    ) u_bounds (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_loop), .field(fld),
        .data(cfg_data), .init_o(init_r), .fin_o(fin_r), .step_o(step_r)
    );

    nlc_term_detect #(
        .N_LOOPS(N_LOOPS), .IDX_W(IDX_W)
    ) u_term (
        .idx(idx_r), .fin(fin_r), .flags(flags)
    );

    nlc_nest_decide #(
        .N_LOOPS(N_LOOPS)
    ) u_decide (
        .flags(flags), .body_done(body_done), .step_v(step_v),
        .reload_v(reload_v), .all_term(all_term)
    );

    nlc_index_bank #(
        .N_LOOPS(N_LOOPS), .IDX_W(IDX_W)
    ) u_bank (
        .clk(clk), .rst(rst), .load_all(start), .adv(adv),
        .step_v(step_v), .reload_v(reload_v),
        .init_i(init_r), .step_i(step_r), .idx_o(idx_r)
    );

    // run control: start wins over a completing body
    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            loops_done <= 1'b0;
        end else begin
            loops_done <= 1'b0;
            if (start) begin
                phase <= PH_RUN;
            end else if (adv && all_term) begin
                phase      <= PH_IDLE;
                loops_done <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < N_LOOPS; g++) begin : g_flat
        assign idx_o[g*IDX_W +: IDX_W] = idx_r[g];
    end

endmodule

// File: rtl/nlc_checker.sv
module nlc_checker
    import nlc_pkg::*;
#(
    parameter int unsigned N_LOOPS = DEF_LOOPS,
    parameter int unsigned IDX_W   = DEF_IDX_W
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     start,
    input logic                     body_done,
    input logic [N_LOOPS*IDX_W-1:0] idx_o,
    input logic                     loops_done,
    input logic                     running,
    input logic [N_LOOPS-1:0]       step_v,
    input logic [N_LOOPS-1:0]       reload_v
);

    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    // R1: the edge after a reset cycle leaves everything cleared
    always_ff @(posedge clk) begin
        if (rst_q) begin
            a_r1_reset_clear: assert (idx_o == '0 && !loops_done)
                else $error("R1 state not cleared by reset");
        end
    end

    a_r2_start_runs: assert property (@(posedge clk) disable iff (rst)
        start |=> running);

    a_r3_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (!body_done && !start) |=> $stable(idx_o));

    a_r5_step_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(step_v));

    a_r5_reload_thermo: assert property (@(posedge clk) disable iff (rst)
        is_thermo(32'(reload_v)));

    a_r5_no_step_in_run: assert property (@(posedge clk) disable iff (rst)
        (step_v & reload_v) == '0);

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        loops_done |=> !loops_done);

    a_r6_done_stops: assert property (@(posedge clk) disable iff (rst)
        loops_done |-> !running);

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!running && !start) |=> $stable(idx_o));

endmodule

bind loop_nest_ctrl nlc_checker #(
    .N_LOOPS(N_LOOPS), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .body_done(body_done),
    .idx_o(idx_o), .loops_done(loops_done), .running(running),
    .step_v(step_v), .reload_v(reload_v)
);

// File: tb/loop_nest_ctrl_test.sv
`timescale 1ns/1ps
module loop_nest_ctrl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_loop;
    logic [1:0]  cfg_field;
    logic [15:0] cfg_data;
    logic        start;
    logic        body_done;
    logic [79:0] idx_o;
    logic        loops_done;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [15:0] b_init [5];
    logic [15:0] b_step [5];
    int          trip   [5];
    int unsigned seed = 32'h1234_5678;

    always #5 clk = ~clk;

    loop_nest_ctrl uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_loop(cfg_loop),
        .cfg_field(cfg_field), .cfg_data(cfg_data), .start(start),
        .body_done(body_done), .idx_o(idx_o), .loops_done(loops_done)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int unsigned rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed >> 8;
    endfunction

    function automatic logic [79:0] exp_vec(input int c [5]);
        logic [79:0] v;
        for (int k = 0; k < 5; k++) begin
            v[k*16 +: 16] = b_init[k] + 16'(c[k]) * b_step[k];
        end
        return v;
    endfunction

    task automatic prog_all();
        cfg_we = 1'b1;
        for (int k = 0; k < 5; k++) begin
            cfg_loop = 3'(k);
            cfg_field = 2'd0; cfg_data = b_init[k]; tick();
            cfg_field = 2'd1; cfg_data = b_init[k] + 16'(trip[k] - 1) * b_step[k]; tick();
            cfg_field = 2'd2; cfg_data = b_step[k]; tick();
        end
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1; tick(); start = 1'b0;
    endtask

    task automatic pulse_body();
        body_done = 1'b1; tick(); body_done = 1'b0;
    endtask

    task automatic set_bounds(input int t0, t1, t2, t3, t4);
        trip[0] = t0; trip[1] = t1; trip[2] = t2; trip[3] = t3; trip[4] = t4;
        for (int k = 0; k < 5; k++) begin
            b_init[k] = 16'(100 * k + 7);
            b_step[k] = 16'(k + 2);
        end
    endtask

    task automatic t_reset();
        int c [5] = '{0, 0, 0, 0, 0};
        rst = 1'b1; cfg_we = 1'b0; cfg_loop = '0; cfg_field = '0; cfg_data = '0;
        start = 1'b0; body_done = 1'b0;
        repeat (3) tick();
        chk("R1 indices after reset", idx_o, 80'h0);
        chk("R1 loops_done after reset", 80'(loops_done), 80'h0);
        rst = 1'b0;
        for (int k = 0; k < 5; k++) begin b_init[k] = 16'h0; b_step[k] = 16'h0; end
        pulse_body();
        chk("R7 body_done before first start", idx_o, exp_vec(c));
    endtask

    task automatic t_basic();
        int c [5] = '{0, 0, 0, 0, 0};
        set_bounds(3, 2, 2, 2, 2);
        prog_all();
        pulse_start();
        chk("R2 start loads initial values", idx_o, exp_vec(c));
        repeat (3) tick();
        chk("R3 hold without body_done", idx_o, exp_vec(c));
        pulse_body();
        c[0] = 1;
        chk("R4 innermost step", idx_o, exp_vec(c));
        tick();
        chk("R3 hold after step", idx_o, exp_vec(c));
    endtask

    task automatic t_carry();
        int c [5] = '{0, 0, 0, 0, 0};
        set_bounds(2, 2, 3, 2, 2);
        prog_all();
        pulse_start();
        pulse_body(); c[0] = 1;
        chk("R4 loop0 reaches final", idx_o, exp_vec(c));
        pulse_body(); c[0] = 0; c[1] = 1;
        chk("R5 k=0 loop1 steps, loop0 reloads", idx_o, exp_vec(c));
        pulse_body(); c[0] = 1;
        pulse_body(); c[0] = 0; c[1] = 0; c[2] = 1;
        chk("R5 k=1 loop2 steps, loops 0..1 reload", idx_o, exp_vec(c));
    endtask

    task automatic t_done();
        int c [5] = '{0, 0, 0, 0, 0};
        set_bounds(2, 1, 1, 1, 1);
        prog_all();
        pulse_start();
        pulse_body(); c[0] = 1;
        chk("R6 no done before completion", 80'(loops_done), 80'h0);
        pulse_body(); c[0] = 0;
        chk("R6 all reload on completion", idx_o, exp_vec(c));
        chk("R6 loops_done high", 80'(loops_done), 80'h1);
        tick();
        chk("R6 loops_done one cycle only", 80'(loops_done), 80'h0);
        pulse_body();
        chk("R7 body_done ignored after completion", idx_o, exp_vec(c));
        chk("R7 no second done pulse", 80'(loops_done), 80'h0);
        pulse_start();
        pulse_body(); c[0] = 1;
        chk("R7 restart accepts body_done", idx_o, exp_vec(c));
    endtask

    task automatic t_wrap();
        int c [5] = '{0, 0, 0, 0, 0};
        set_bounds(2, 2, 1, 1, 1);
        b_init[0] = 16'hFFFE; b_step[0] = 16'h0003;
        prog_all();
        pulse_start();
        pulse_body(); c[0] = 1;
        chk("R9 wrap to 0x0001", 80'(idx_o[15:0]), 80'h0001);
        pulse_body(); c[0] = 0; c[1] = 1;
        chk("R9 wrapped final detected", idx_o, exp_vec(c));
    endtask

    task automatic t_nest(input int run_no);
        int c [5] = '{0, 0, 0, 0, 0};
        int iters = 0;
        int prod = 1;
        bit fin_seen = 0;
        for (int k = 0; k < 5; k++) begin
            trip[k]   = int'(rnd() % 4) + 1;
            b_init[k] = 16'(rnd());
            b_step[k] = 16'(rnd() | 1);
            prod      = prod * trip[k];
        end
        prog_all();
        pulse_start();
        while (!fin_seen && iters < 5000) begin
            bit carry = 1'b1;
            chk($sformatf("R8 run %0d index at iteration %0d", run_no, iters), idx_o, exp_vec(c));
            pulse_body();
            iters++;
            for (int k = 0; k < 5; k++) begin
                if (carry) begin
                    if (c[k] + 1 < trip[k]) begin c[k]++; carry = 1'b0; end
                    else c[k] = 0;
                end
            end
            fin_seen = carry;
            chk($sformatf("R8 run %0d done flag", run_no), 80'(loops_done), 80'(fin_seen));
        end
        chk($sformatf("R8 run %0d iteration count", run_no), 80'(iters), 80'(prod));
    endtask

    initial begin
        t_reset();
        t_basic();
        t_carry();
        t_done();
        t_wrap();
        for (int r = 0; r < 4; r++) t_nest(r);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule